// File: doc/BRIEF.md
# Flash Controller Command Register with Key Unlock

This block is the command register that software uses to steer a flash memory sequencer. It holds the operation selects (word program, page erase, mass erase, fast program), a four-bit page number, three interrupt enables, and several trigger bits. Two of the triggers start an operation and one requests a reload of option settings. Software may only set these triggers. The sequencer clears them through its busy and load-done inputs.

Writes are guarded by two nested locks. The register lock blocks every write to the command register. The option lock additionally blocks the option-related triggers. Each lock opens only after two consecutive writes of a fixed key pair to its own key register. The option pair is honoured only once the register lock is open. Any mistake in a sequence jams that lock shut until the next reset. The block also combines the interrupt enables with the status flags from the sequencer into three interrupt lines.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the command word (address 0) reads 0xC000_0000: bit 31 (register lock) and bit 30 (option lock) are 1 and every other bit and output is 0. The key registers at addresses 1 and 2 read 0.
- R2: While the register lock is 1, a write to address 0 changes nothing. Writing 1 to bit 31 while unlocked sets the lock again; writing 0 there has no effect.
- R3: Writing 0x5A17_C3E9 and then 0x0F6B_2D84 to address 1, with no other bus write in between, clears the register lock one cycle after the second write.
- R4: A wrong value, the keys in the wrong order, or any other bus write between the two keys leaves the register lock at 1 for good until reset. Later correct sequences and writes to address 0 then have no effect.
- R5: Writing 0x3C9E_71A5 and then 0xB24D_086F to address 2 clears the option lock, but only while the register lock is 0. A key write to address 2 while the register lock is 1, or any sequence error, holds the option lock at 1 until reset. Writing 1 to bit 30 sets it again.
- R6: While the option lock is 1, writes to bits 9 and 10 are ignored.
- R7: Bit 9 (option start) is set only by software. It clears in the cycle after busy channel 1 falls from 1 to 0. A fall on busy channel 2 does not clear it.
- R8: Bit 8 (start) is set only by software; writing 0 to it has no effect. It clears in the cycle after either busy input falls from 1 to 0.
- R9: Bit 10 (option load request) is set only by software and holds until load_done is high at a clock edge, which clears it. A set in the same cycle wins.
- R10: Bit 20 (secure-area protect) can be set only while sec_size is nonzero, and only reset clears it.
- R11: Bits 0 (program), 1 (page erase), 2 (mass erase), 3 (fast program), 7:4 (page number), 12 (end-of-operation IE), 13 (error IE) and 14 (read-error IE) are read/write and drive the matching outputs.
- R12: irq_eop, irq_err and irq_rderr are each the AND of their enable bit with eop_flag, operr_flag and rderr_flag respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 command, 1 lock key, 2 option key |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| bsy1 | input | 1 | Busy from sequencer channel 1 |
| bsy2 | input | 1 | Busy from sequencer channel 2 |
| load_done | input | 1 | Option load finished |
| sec_size | input | 5 | Secure-area size; zero means no secure area |
| eop_flag | input | 1 | End-of-operation status flag |
| operr_flag | input | 1 | Operation error status flag |
| rderr_flag | input | 1 | Protected-read error status flag |
| prog_en | output | 1 | Program select |
| perase_en | output | 1 | Page erase select |
| mass_erase | output | 1 | Mass erase select |
| fast_prog | output | 1 | Fast program select |
| page_sel | output | 4 | Page number |
| start | output | 1 | Start trigger |
| opt_start | output | 1 | Option operation trigger |
| opt_load | output | 1 | Option load request |
| secure_prot | output | 1 | Secure-area protection active |
| irq_eop | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_rderr | output | 1 | Read-error interrupt |

## Verification
The busy-fall properties use a one-cycle history of bsy1 and bsy2. They therefore assume both busy inputs are low while reset is held, so that no fall is seen on the first edge after reset. The stimulus keeps both busy lines at 0 except inside the tasks that pulse them. It raises them only after reset is released.

The protection properties assume every write reaches the block as a single-cycle strobe with the address and data stable for that cycle. The bench's write task issues exactly that and returns the strobe to 0 between writes.

// File: rtl/flash_ctl_pkg.sv
// Shared constants for the flash command register: widths, register
// addresses, bit positions in the command word, and the unlock keys.
package flash_ctl_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int PAGE_W  = 4;
    localparam int SEC_W   = 5;
    localparam int N_TRIG  = 4;
    localparam int PLAIN_W = 4 + PAGE_W + 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_OKEY = 2'd2;

    localparam int BIT_PROG     = 0;
    localparam int BIT_PERASE   = 1;
    localparam int BIT_MASS     = 2;
    localparam int BIT_FAST     = 3;
    localparam int PAGE_LSB     = 4;
    localparam int BIT_START    = 8;
    localparam int BIT_OPTSTART = 9;
    localparam int BIT_OPTLOAD  = 10;
    localparam int BIT_EOPIE    = 12;
    localparam int BIT_ERRIE    = 13;
    localparam int BIT_RDERRIE  = 14;
    localparam int BIT_SECURE   = 20;
    localparam int BIT_OPTLOCK  = 30;
    localparam int BIT_LOCK     = 31;

    // Indices into the set-only trigger bank
    localparam int TRIG_START = 0;
    localparam int TRIG_OPTST = 1;
    localparam int TRIG_OLOAD = 2;
    localparam int TRIG_SECUR = 3;

    localparam logic [DATA_W-1:0] LOCK_KEY_A = 32'h5A17_C3E9;
    localparam logic [DATA_W-1:0] LOCK_KEY_B = 32'h0F6B_2D84;
    localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h3C9E_71A5;
    localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'hB24D_086F;

    typedef enum logic [1:0] {
        UL_WAIT_A = 2'd0,
        UL_WAIT_B = 2'd1,
        UL_OPEN   = 2'd2,
        UL_DEAD   = 2'd3
    } unlock_st_e;
endpackage

// File: rtl/flash_unlock_seq.sv
// Two-key unlock sequencer for one lock bit.
// The lock opens after KEY_A then KEY_B are written to this lock's key
// register with no other bus write in between, and only while 'allow' is
// high. Any error moves to a dead state that holds the lock until reset.
// Assumes key_wr and other_wr are one-cycle strobes that are never both high.
module flash_unlock_seq
    import flash_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = LOCK_KEY_A,
    parameter logic [DATA_W-1:0] KEY_B = LOCK_KEY_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              allow,
    input  logic              relock,
    output logic              locked,
    output logic              dead
);
    unlock_st_e st_q, st_d;

    // Next-state decode for the key sequence
    always_comb begin
        st_d = st_q;
        case (st_q)
            UL_WAIT_A: if (key_wr) st_d = (allow && key_data == KEY_A) ? UL_WAIT_B : UL_DEAD;
            UL_WAIT_B: begin
                if (key_wr)        st_d = (allow && key_data == KEY_B) ? UL_OPEN : UL_DEAD;
                else if (other_wr) st_d = UL_DEAD;
            end
            UL_OPEN:   if (relock) st_d = UL_WAIT_A;
            default:   st_d = UL_DEAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UL_WAIT_A;
        else        st_q <= st_d;
    end

    assign locked = (st_q != UL_OPEN);
    assign dead   = (st_q == UL_DEAD);
endmodule

// File: rtl/flash_set_only.sv
// Bank of bits that software can only set and that hardware clears.
// A set in the same cycle as a clear wins, so a new request is never lost.
module flash_set_only #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One set-dominant flag
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_ctl_reg.sv
// Flash command register with a register lock and an option lock.
// Decodes a simple single-cycle write port. The read port is combinational.
// Holds the plain operation fields, keeps the set-only triggers in a
// separate bank, and forms the interrupt lines.
// Assumes bsy1/bsy2 are synchronous to clk and low during reset.
module flash_ctl_reg
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bsy1,
    input  logic              bsy2,
    input  logic              load_done,
    input  logic [SEC_W-1:0]  sec_size,
    input  logic              eop_flag,
    input  logic              operr_flag,
    input  logic              rderr_flag,
    output logic              prog_en,
    output logic              perase_en,
    output logic              mass_erase,
    output logic              fast_prog,
    output logic [PAGE_W-1:0] page_sel,
    output logic              start,
    output logic              opt_start,
    output logic              opt_load,
    output logic              secure_prot,
    output logic              irq_eop,
    output logic              irq_err,
    output logic              irq_rderr
);
    logic              lock_q, opt_lock_q, main_dead, opt_dead;
    logic              wr_ctrl, wr_key, wr_okey, opt_ok;
    logic              bsy1_q, bsy2_q, fall1, fall2;
    logic              eop_ie, err_ie, rderr_ie;
    logic [N_TRIG-1:0] trig_set, trig_clr, trig_q;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL) && !lock_q;
    assign wr_key  = bus_wr && (bus_addr == ADDR_KEY);
    assign wr_okey = bus_wr && (bus_addr == ADDR_OKEY);
    assign opt_ok  = wr_ctrl && !opt_lock_q;

    flash_unlock_seq #(.KEY_A(LOCK_KEY_A), .KEY_B(LOCK_KEY_B)) u_main_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .other_wr (bus_wr && !wr_key),
        .key_data (bus_wdata),
        .allow    (1'b1),
        .relock   (wr_ctrl && bus_wdata[BIT_LOCK]),
        .locked   (lock_q),
        .dead     (main_dead)
    );

    flash_unlock_seq #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) u_opt_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_okey),
        .other_wr (bus_wr && !wr_okey),
        .key_data (bus_wdata),
        .allow    (!lock_q),
        .relock   (wr_ctrl && bus_wdata[BIT_OPTLOCK]),
        .locked   (opt_lock_q),
        .dead     (opt_dead)
    );

    // Busy history for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsy1_q <= 1'b0;
            bsy2_q <= 1'b0;
        end else begin
            bsy1_q <= bsy1;
            bsy2_q <= bsy2;
        end
    end
    assign fall1 = bsy1_q && !bsy1;
    assign fall2 = bsy2_q && !bsy2;

    // Plain read/write fields, written only while the register lock is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_en    <= 1'b0;
            perase_en  <= 1'b0;
            mass_erase <= 1'b0;
            fast_prog  <= 1'b0;
            page_sel   <= '0;
            eop_ie     <= 1'b0;
            err_ie     <= 1'b0;
            rderr_ie   <= 1'b0;
        end else if (wr_ctrl) begin
            prog_en    <= bus_wdata[BIT_PROG];
            perase_en  <= bus_wdata[BIT_PERASE];
            mass_erase <= bus_wdata[BIT_MASS];
            fast_prog  <= bus_wdata[BIT_FAST];
            page_sel   <= bus_wdata[PAGE_LSB +: PAGE_W];
            eop_ie     <= bus_wdata[BIT_EOPIE];
            err_ie     <= bus_wdata[BIT_ERRIE];
            rderr_ie   <= bus_wdata[BIT_RDERRIE];
        end
    end

    // Set and clear conditions for the trigger bank
    always_comb begin
        trig_set             = '0;
        trig_clr             = '0;
        trig_set[TRIG_START] = wr_ctrl && bus_wdata[BIT_START];
        trig_clr[TRIG_START] = fall1 || fall2;
        trig_set[TRIG_OPTST] = opt_ok && bus_wdata[BIT_OPTSTART];
        trig_clr[TRIG_OPTST] = fall1;
        trig_set[TRIG_OLOAD] = opt_ok && bus_wdata[BIT_OPTLOAD];
        trig_clr[TRIG_OLOAD] = load_done;
        trig_set[TRIG_SECUR] = wr_ctrl && bus_wdata[BIT_SECURE] && (sec_size != '0);
    end

    flash_set_only #(.N(N_TRIG)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (trig_set),
        .clr   (trig_clr),
        .q     (trig_q)
    );

    assign start       = trig_q[TRIG_START];
    assign opt_start   = trig_q[TRIG_OPTST];
    assign opt_load    = trig_q[TRIG_OLOAD];
    assign secure_prot = trig_q[TRIG_SECUR];

    assign irq_eop   = eop_ie   && eop_flag;
    assign irq_err   = err_ie   && operr_flag;
    assign irq_rderr = rderr_ie && rderr_flag;

    // Assemble the command word as read back
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[BIT_PROG]              = prog_en;
        ctrl_word[BIT_PERASE]            = perase_en;
        ctrl_word[BIT_MASS]              = mass_erase;
        ctrl_word[BIT_FAST]              = fast_prog;
        ctrl_word[PAGE_LSB +: PAGE_W]    = page_sel;
        ctrl_word[BIT_START]             = start;
        ctrl_word[BIT_OPTSTART]          = opt_start;
        ctrl_word[BIT_OPTLOAD]           = opt_load;
        ctrl_word[BIT_EOPIE]             = eop_ie;
        ctrl_word[BIT_ERRIE]             = err_ie;
        ctrl_word[BIT_RDERRIE]           = rderr_ie;
        ctrl_word[BIT_SECURE]            = secure_prot;
        ctrl_word[BIT_OPTLOCK]           = opt_lock_q;
        ctrl_word[BIT_LOCK]              = lock_q;
    end

    assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl_word : '0;
endmodule

// File: rtl/flash_ctl_reg_chk.sv
// Property checker for flash_ctl_reg, attached through bind.
// Assumes single-cycle write strobes and busy inputs low during reset.
module flash_ctl_reg_chk
    import flash_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               wd_start,
    input logic               bsy1,
    input logic               bsy2,
    input logic               load_done,
    input logic               lock_q,
    input logic               opt_lock_q,
    input logic               main_dead,
    input logic [PLAIN_W-1:0] plain_bits,
    input logic               start,
    input logic               opt_start,
    input logic               opt_load,
    input logic               secure_prot
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);

    assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && lock_q) |=> $stable(plain_bits));

    assert_unlock_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(bus_wr && bus_addr == ADDR_KEY));

    assert_lockout_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        main_dead |=> lock_q);

    assert_opt_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && opt_lock_q && !opt_start) |=> !opt_start);

    assert_start_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(bsy1) || $fell(bsy2)) && !(ctrl_wr && !lock_q && wd_start)) |=> !start);

    assert_load_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_load && !load_done) |=> opt_load);

    assert_secure_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        secure_prot |=> secure_prot);
endmodule

bind flash_ctl_reg flash_ctl_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wd_start    (bus_wdata[8]),
    .bsy1        (bsy1),
    .bsy2        (bsy2),
    .load_done   (load_done),
    .lock_q      (lock_q),
    .opt_lock_q  (opt_lock_q),
    .main_dead   (main_dead),
    .plain_bits  ({ctrl_word[7:0], ctrl_word[14:12]}),
    .start       (start),
    .opt_start   (opt_start),
    .opt_load    (opt_load),
    .secure_prot (secure_prot)
);

// File: tb/tb_flash_ctl_reg.sv
// Directed bench for flash_ctl_reg: one task per scenario.
module tb_flash_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bsy1 = 1'b0, bsy2 = 1'b0, load_done = 1'b0;
    logic [4:0]  sec_size = 5'd0;
    logic        eop_flag = 1'b0, operr_flag = 1'b0, rderr_flag = 1'b0;
    logic        prog_en, perase_en, mass_erase, fast_prog;
    logic [3:0]  page_sel;
    logic        start, opt_start, opt_load, secure_prot;
    logic        irq_eop, irq_err, irq_rderr;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] KA = 32'h5A17_C3E9, KB = 32'h0F6B_2D84;
    localparam logic [31:0] OA = 32'h3C9E_71A5, OB = 32'hB24D_086F;

    always #2 clk = ~clk;

    flash_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bsy1(bsy1), .bsy2(bsy2),
        .load_done(load_done), .sec_size(sec_size), .eop_flag(eop_flag),
        .operr_flag(operr_flag), .rderr_flag(rderr_flag), .prog_en(prog_en),
        .perase_en(perase_en), .mass_erase(mass_erase), .fast_prog(fast_prog),
        .page_sel(page_sel), .start(start), .opt_start(opt_start),
        .opt_load(opt_load), .secure_prot(secure_prot), .irq_eop(irq_eop),
        .irq_err(irq_err), .irq_rderr(irq_rderr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 32'd0;
        #1;
    endtask

    task automatic unlock_main();
        wr(2'd1, KA);
        wr(2'd1, KB);
    endtask

    // Pulse one busy line high for a cycle, then low; the clear shows after the fall edge
    task automatic busy_pulse(input bit which);
        @(negedge clk);
        if (which) bsy2 = 1'b1; else bsy1 = 1'b1;
        @(negedge clk);
        bsy1 = 1'b0; bsy2 = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 ctrl word", bus_rdata, 32'hC000_0000);
        check("R1 outputs", {28'd0, start, opt_start, opt_load, secure_prot}, 32'd0);
        bus_addr = 2'd1; #1;
        check("R1 key reg reads 0", bus_rdata, 32'd0);
        bus_addr = 2'd0; #1;
    endtask

    task automatic t_locked_and_unlock();
        do_reset();
        wr(2'd0, 32'h0000_71FF);
        check("R2 locked write ignored", bus_rdata, 32'hC000_0000);
        wr(2'd1, KA);
        check("R3 lock held after first key", bus_rdata, 32'hC000_0000);
        wr(2'd1, KB);
        check("R3 lock cleared", bus_rdata, 32'h4000_0000);
        wr(2'd0, 32'h8000_0000);
        check("R2 relock by software", bus_rdata, 32'hC000_0000);
        unlock_main();
        check("R3 unlock after relock", bus_rdata, 32'h4000_0000);
    endtask

    task automatic t_fields_irq();
        do_reset();
        unlock_main();
        wr(2'd0, 32'h4000_70A7);
        check("R11 field readback", bus_rdata, 32'h4000_70A7);
        check("R11 field outputs", {24'd0, page_sel, fast_prog, mass_erase, perase_en, prog_en},
              32'h0000_00A7);
        eop_flag = 1'b1; operr_flag = 1'b0; rderr_flag = 1'b1; #1;
        check("R12 irq with enables", {29'd0, irq_eop, irq_err, irq_rderr}, 32'd5);
        wr(2'd0, 32'h0000_2000);
        operr_flag = 1'b1; #1;
        check("R12 irq only err enabled", {29'd0, irq_eop, irq_err, irq_rderr}, 32'd2);
        eop_flag = 1'b0; operr_flag = 1'b0; rderr_flag = 1'b0;
        wr(2'd0, 32'h0000_0000);
        check("R11 fields cleared, option lock kept", bus_rdata, 32'h4000_0000);
    endtask

    task automatic t_start();
        do_reset();
        unlock_main();
        wr(2'd0, 32'h0000_0100);
        check("R8 start set", {31'd0, start}, 32'd1);
        wr(2'd0, 32'h0000_0000);
        check("R8 write 0 keeps start", {31'd0, start}, 32'd1);
        busy_pulse(1'b1);
        check("R8 cleared by busy2 fall", {31'd0, start}, 32'd0);
        wr(2'd0, 32'h0000_0100);
        busy_pulse(1'b0);
        check("R8 cleared by busy1 fall", {31'd0, start}, 32'd0);
    endtask

    task automatic t_options();
        do_reset();
        unlock_main();
        wr(2'd0, 32'h0000_0600);
        check("R6 option bits blocked", {30'd0, opt_start, opt_load}, 32'd0);
        wr(2'd2, OA);
        wr(2'd2, OB);
        check("R5 option lock cleared", bus_rdata, 32'h0000_0000);
        wr(2'd0, 32'h0000_0600);
        check("R6 option bits set", bus_rdata, 32'h0000_0600);
        busy_pulse(1'b1);
        check("R7 busy2 fall keeps opt_start", {31'd0, opt_start}, 32'd1);
        busy_pulse(1'b0);
        check("R7 busy1 fall clears opt_start", {31'd0, opt_start}, 32'd0);
        wr(2'd0, 32'h0000_0000);
        check("R9 software cannot clear load", {31'd0, opt_load}, 32'd1);
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0; #1;
        check("R9 load_done clears", {31'd0, opt_load}, 32'd0);
        wr(2'd0, 32'h4000_0000);
        wr(2'd0, 32'h0000_0600);
        check("R5 relocked option blocks", bus_rdata, 32'h4000_0000);
    endtask

    task automatic t_secure();
        do_reset();
        unlock_main();
        sec_size = 5'd0;
        wr(2'd0, 32'h0010_0000);
        check("R10 no area, not set", {31'd0, secure_prot}, 32'd0);
        sec_size = 5'd3;
        wr(2'd0, 32'h0010_0000);
        check("R10 set with area", {31'd0, secure_prot}, 32'd1);
        wr(2'd0, 32'h0000_0000);
        check("R10 write 0 keeps", {31'd0, secure_prot}, 32'd1);
        do_reset();
        check("R10 reset clears", {31'd0, secure_prot}, 32'd0);
        sec_size = 5'd0;
    endtask

    task automatic t_lockouts();
        do_reset();
        wr(2'd1, KB);
        unlock_main();
        check("R4 wrong order locks out", bus_rdata, 32'hC000_0000);
        wr(2'd0, 32'h0000_000F);
        check("R4 writes stay ignored", bus_rdata, 32'hC000_0000);
        do_reset();
        wr(2'd1, KA);
        wr(2'd0, 32'h0000_0001);
        wr(2'd1, KB);
        check("R4 interrupted sequence", bus_rdata, 32'hC000_0000);
        do_reset();
        wr(2'd1, KA ^ 32'h1);
        unlock_main();
        check("R4 wrong value", bus_rdata, 32'hC000_0000);
        do_reset();
        wr(2'd2, OA);
        unlock_main();
        wr(2'd2, OA);
        wr(2'd2, OB);
        check("R5 option key while locked jams", bus_rdata, 32'h4000_0000);
        do_reset();
        unlock_main();
        check("R4 reset recovers", bus_rdata, 32'h4000_0000);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_locked_and_unlock();
        t_fields_irq();
        t_start();
        t_options();
        t_secure();
        t_lockouts();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule